// File: doc/BRIEF.md
# Interrupt Distributor with Priority Arbitration

This block keeps the enable, pending, active, priority, target and trigger-mode state for a parameterised set of interrupt lines. Every cycle it picks one interrupt to offer to a single CPU interface. A line is a candidate when it is enabled, pending, not active and has target bit 0 set. Among the candidates, the one with the numerically lowest priority value wins. IDs 0 to 15 are software-generated and are raised by one-cycle pulses. IDs 16 to 31 are private peripheral lines and IDs 32 and up are shared peripheral lines; both come in on the raw peripheral input bus.

Software reaches the block through a word-addressed register port. Writes take effect at the clock edge and reads are combinational. The CPU interface takes the offered interrupt with a one-cycle acknowledge strobe and retires it with an end-of-interrupt strobe that carries the ID. These two strobes drive each line through its pending and active states. Edge-triggered lines latch a pending bit on a rising edge. Level-sensitive lines are pending for as long as their input is high.

Register map (word addresses): 0x00 control (bit 0 = distributor on); 0x01 line count (read only); 0x08+n set-enable; 0x10+n clear-enable; 0x18+n clear-pending (reads return pending); 0x20+n active (read only); 0x28+n trigger mode; 0x40+k priority; 0x80+k target.

Top module: `irq_distributor`

## Requirements
- R1: After reset, the control bit, all enables, pending bits, active bits, priorities, targets and trigger-mode bits of IDs 16 and up read 0, and `fwd_valid` is 0.
- R2: Writing word n at 0x08+n sets the enable of ID 32·n+b for every 1 bit b. 0 bits leave enables unchanged. Reads of 0x08+n and 0x10+n both return the enable word.
- R3: Writing word n at 0x10+n clears the enable of ID 32·n+b for every 1 bit b. 0 bits leave enables unchanged.
- R4: A line whose enable is 0 is never offered, even while it is pending.
- R5: The offered ID is a line that is enabled, pending, not active and has target bit 0 set, and whose 8-bit priority value is the smallest among such lines. A tie goes to the lowest ID. `fwd_prio` carries the winner's priority.
- R6: With control bit 0 of word 0x00 at 0, `fwd_valid` is 0. Setting that bit lets arbitration results through on the next cycle.
- R7: Trigger-mode bit b of word 0x28+n is 1 for edge and 0 for level, for ID 32·n+b. IDs 0–15 are always edge and read as 1. An edge line becomes pending the cycle after a 0→1 input transition (or after its `sw_pulse` bit for IDs 0–15). An acknowledge clears the pending bit unless a new edge arrives in the same cycle.
- R8: A level line's pending bit equals its input as sampled at the previous clock edge, including while the line is active.
- R9: `cpu_ack` while `fwd_valid` is 1 makes the offered ID active from the next cycle. An active line is not offered. `eoi_valid` with `eoi_id` clears that line's active bit.
- R10: Writing 1 to bit b of word 0x18+n clears the pending bit of edge line 32·n+b. 0 bits have no effect.
- R11: Word 0x01 reads (number of lines / 32) − 1 in bits [4:0].
- R12: Priority word 0x40+k and target word 0x80+k hold IDs 4k..4k+3, with ID 4k+j in bits [8j+7:8j]. Writes store and reads return the full bytes.
- R13: `cpu_ack` while `fwd_valid` is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| periph_in | input | NUM_IRQ-16 | Raw peripheral lines for IDs 16 and up |
| sw_pulse | input | 16 | One-cycle software-generated requests for IDs 0–15 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| fwd_valid | output | 1 | An interrupt is offered to the CPU interface |
| fwd_id | output | IDW | Offered interrupt ID |
| fwd_prio | output | 8 | Offered interrupt priority |
| cpu_ack | input | 1 | CPU interface takes the offered interrupt |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | IDW | ID being retired |

## Verification
The assertions assume that `eoi_id` names a line that software actually acknowledged earlier, and that `cpu_ack` is a single-cycle strobe. They also assume that peripheral inputs and pulses are held low while reset is asserted, so the level-tracking property starts from agreeing state. The stimulus only retires IDs it has taken, pulses every strobe for exactly one cycle, and keeps all inputs at 0 until reset is released. The bench's reference model then follows every write, edge, acknowledge and retirement and compares the offered ID each cycle.

// File: rtl/dist_pkg.sv
package dist_pkg;
  localparam int REG_CTRL    = 'h00;
  localparam int REG_LINES   = 'h01;
  localparam int REG_ENSET   = 'h08;
  localparam int REG_ENCLR   = 'h10;
  localparam int REG_PENDCLR = 'h18;
  localparam int REG_ACTIVE  = 'h20;
  localparam int REG_MODE    = 'h28;
  localparam int REG_PRIO    = 'h40;
  localparam int REG_TARGET  = 'h80;
  localparam int NUM_SW      = 16;
  typedef logic [7:0] prio_t;
endpackage

// File: rtl/dist_rst_sync.sv
module dist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/dist_line_state.sv
module dist_line_state #(
  parameter int NUM_IRQ = 64,
  parameter int IDW     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:16] periph_in,
  input  logic [15:0]        sw_pulse,
  input  logic [NUM_IRQ-1:16] edge_cfg,
  input  logic [NUM_IRQ-1:0] clr_pend,
  input  logic               ack_fire,
  input  logic [IDW-1:0]     ack_id,
  input  logic               eoi_valid,
  input  logic [IDW-1:0]     eoi_id,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] act_q
);
  logic [NUM_IRQ-1:16] prev_q;
  logic [NUM_IRQ-1:0]  edge_eff, lvl_in, set_v, ack_hit, eoi_hit, pend_d, act_d;
  logic                run_q;

  always_comb begin
    edge_eff = {edge_cfg, 16'hFFFF};
    lvl_in   = {periph_in, 16'h0000};
    set_v    = {periph_in & ~prev_q & edge_cfg, sw_pulse};
    for (int i = 0; i < NUM_IRQ; i++) begin
      ack_hit[i] = ack_fire && (ack_id == IDW'(i));
      eoi_hit[i] = eoi_valid && (eoi_id == IDW'(i));
      if (edge_eff[i]) pend_d[i] = set_v[i] | (pend_q[i] & ~(ack_hit[i] | clr_pend[i]));
      else             pend_d[i] = lvl_in[i];
      act_d[i] = ack_hit[i] | (act_q[i] & ~eoi_hit[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      prev_q <= '0;
      run_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      prev_q <= periph_in;
      run_q  <= 1'b1;
    end
  end

  assert_ack_sets_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> act_q[$past(ack_id)]);

  assert_level_tracks_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> ((pend_q & ~$past(edge_eff)) == ($past(lvl_in) & ~$past(edge_eff))));

  assert_edge_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && edge_eff[ack_id] && !set_v[ack_id]) |=> !pend_q[$past(ack_id)]);
endmodule

// File: rtl/dist_arbiter.sv
module dist_arbiter
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int IDW     = 6
) (
  input  logic [NUM_IRQ-1:0]        elig,
  input  prio_t [NUM_IRQ-1:0]       prio,
  output logic                      win_valid,
  output logic [IDW-1:0]            win_id,
  output prio_t                     win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = 8'hFF;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i] && (!win_valid || (prio[i] < win_prio))) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int AW      = 8,
  parameter int IDW     = $clog2(NUM_IRQ)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_IRQ-1:16] periph_in,
  input  logic [15:0]         sw_pulse,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [31:0]         rd_data,
  output logic                fwd_valid,
  output logic [IDW-1:0]      fwd_id,
  output logic [7:0]          fwd_prio,
  input  logic                cpu_ack,
  input  logic                eoi_valid,
  input  logic [IDW-1:0]      eoi_id
);
  localparam int NWORD = NUM_IRQ / 32;
  localparam int PWORD = NUM_IRQ / 4;

  logic                rst_sync_n;
  logic                dist_en_q, dist_en_d;
  logic [NUM_IRQ-1:0]  en_q, en_d;
  logic [NUM_IRQ-1:16] edge_q, edge_d;
  prio_t [NUM_IRQ-1:0] prio_q, prio_d, tgt_q, tgt_d;
  logic [NUM_IRQ-1:0]  clr_pend, pend_q, act_q, elig, tgt_cpu0;
  logic                win_valid, ack_fire;
  prio_t               win_prio;

  dist_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // Register writes: next-state for configuration
  always_comb begin
    dist_en_d = dist_en_q;
    en_d      = en_q;
    edge_d    = edge_q;
    prio_d    = prio_q;
    tgt_d     = tgt_q;
    clr_pend  = '0;
    if (wr_en) begin
      if (wr_addr == AW'(REG_CTRL)) dist_en_d = wr_data[0];
      for (int w = 0; w < NWORD; w++) begin
        if (wr_addr == AW'(REG_ENSET + w))   en_d[w*32 +: 32] = en_q[w*32 +: 32] | wr_data;
        if (wr_addr == AW'(REG_ENCLR + w))   en_d[w*32 +: 32] = en_q[w*32 +: 32] & ~wr_data;
        if (wr_addr == AW'(REG_PENDCLR + w)) clr_pend[w*32 +: 32] = wr_data;
      end
      for (int i = NUM_SW; i < NUM_IRQ; i++) begin
        if (wr_addr == AW'(REG_MODE + i / 32)) edge_d[i] = wr_data[i % 32];
      end
      for (int k = 0; k < PWORD; k++) begin
        for (int b = 0; b < 4; b++) begin
          if (wr_addr == AW'(REG_PRIO + k))   prio_d[4*k+b] = wr_data[8*b +: 8];
          if (wr_addr == AW'(REG_TARGET + k)) tgt_d[4*k+b]  = wr_data[8*b +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dist_en_q <= 1'b0;
      en_q      <= '0;
      edge_q    <= '0;
      prio_q    <= '0;
      tgt_q     <= '0;
    end else if (wr_en) begin
      dist_en_q <= dist_en_d;
      en_q      <= en_d;
      edge_q    <= edge_d;
      prio_q    <= prio_d;
      tgt_q     <= tgt_d;
    end
  end

  // Register reads
  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(REG_CTRL))  rd_data[0] = dist_en_q;
    if (rd_addr == AW'(REG_LINES)) rd_data = 32'(NWORD - 1);
    for (int w = 0; w < NWORD; w++) begin
      if (rd_addr == AW'(REG_ENSET + w) || rd_addr == AW'(REG_ENCLR + w)) rd_data = en_q[w*32 +: 32];
      if (rd_addr == AW'(REG_PENDCLR + w)) rd_data = pend_q[w*32 +: 32];
      if (rd_addr == AW'(REG_ACTIVE + w))  rd_data = act_q[w*32 +: 32];
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (rd_addr == AW'(REG_MODE + i / 32)) rd_data[i % 32] = (i < NUM_SW) ? 1'b1 : edge_q[i];
    end
    for (int k = 0; k < PWORD; k++) begin
      for (int b = 0; b < 4; b++) begin
        if (rd_addr == AW'(REG_PRIO + k))   rd_data[8*b +: 8] = prio_q[4*k+b];
        if (rd_addr == AW'(REG_TARGET + k)) rd_data[8*b +: 8] = tgt_q[4*k+b];
      end
    end
  end

  dist_line_state #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_lines (
    .clk(clk), .rst_n(rst_sync_n), .periph_in(periph_in), .sw_pulse(sw_pulse),
    .edge_cfg(edge_q), .clr_pend(clr_pend), .ack_fire(ack_fire), .ack_id(fwd_id),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id), .pend_q(pend_q), .act_q(act_q)
  );

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) tgt_cpu0[i] = tgt_q[i][0];
    elig = en_q & pend_q & ~act_q & tgt_cpu0;
  end

  dist_arbiter #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_arb (
    .elig(elig), .prio(prio_q), .win_valid(win_valid), .win_id(fwd_id), .win_prio(win_prio)
  );

  assign fwd_valid = dist_en_q & win_valid;
  assign fwd_prio  = win_prio;
  assign ack_fire  = cpu_ack & fwd_valid;

  assert_offer_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fwd_valid |-> (en_q[fwd_id] && pend_q[fwd_id] && !act_q[fwd_id] && tgt_q[fwd_id][0]));

  assert_offer_gated_by_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(dist_en_q) |-> !fwd_valid);

  assert_stray_ack_ignored_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fwd_valid |=> ((act_q & ~$past(act_q)) == '0));

  assert_clear_enable_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == AW'(REG_ENCLR) && wr_data[0]) |=> !en_q[0]);
endmodule

// File: tb/sim_irq_distributor.sv
module sim_irq_distributor;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:16] periph = '0;
  logic [15:0] swp = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic fwd_valid;
  logic [5:0] fwd_id;
  logic [7:0] fwd_prio;
  logic cpu_ack = 1'b0, eoi_valid = 1'b0;
  logic [5:0] eoi_id = '0;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_ctrl;
  int m_en[N], m_pend[N], m_act[N], m_prio[N], m_tgt[N], m_edge[N], m_prev[N];

  always #5 clk = ~clk;

  irq_distributor #(.NUM_IRQ(N)) u0 (
    .clk(clk), .rst_n(rst_n), .periph_in(periph), .sw_pulse(swp),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_prio(fwd_prio),
    .cpu_ack(cpu_ack), .eoi_valid(eoi_valid), .eoi_id(eoi_id)
  );

  task automatic find_best(output int v, output int id, output int p);
    v = 0; id = 0; p = 255;
    if (m_ctrl != 0)
      for (int i = 0; i < N; i++)
        if (m_en[i] != 0 && m_pend[i] != 0 && m_act[i] == 0 && (m_tgt[i] & 1) != 0 &&
            (v == 0 || m_prio[i] < p)) begin
          v = 1; id = i; p = m_prio[i];
        end
  endtask

  task automatic model_step();
    int v, id, p, a;
    bit s, clrw, hit;
    int np[N], na[N];
    find_best(v, id, p);
    a = int'(wr_addr);
    for (int i = 0; i < N; i++) begin
      hit = cpu_ack && v != 0 && id == i;
      clrw = wr_en && a == 'h18 + i / 32 && wr_data[i % 32];
      if (i < 16) s = swp[i];
      else s = (m_edge[i] != 0) && periph[i] && m_prev[i] == 0;
      if (i < 16 || m_edge[i] != 0) np[i] = (s || (m_pend[i] != 0 && !(hit || clrw))) ? 1 : 0;
      else np[i] = periph[i] ? 1 : 0;
      na[i] = (hit || (m_act[i] != 0 && !(eoi_valid && int'(eoi_id) == i))) ? 1 : 0;
    end
    for (int i = 0; i < N; i++) begin
      m_pend[i] = np[i];
      m_act[i] = na[i];
      if (i >= 16) m_prev[i] = periph[i] ? 1 : 0;
    end
    if (wr_en) begin
      if (a == 0) m_ctrl = wr_data[0];
      for (int i = 0; i < N; i++) begin
        if (a == 'h08 + i / 32 && wr_data[i % 32]) m_en[i] = 1;
        if (a == 'h10 + i / 32 && wr_data[i % 32]) m_en[i] = 0;
        if (i >= 16 && a == 'h28 + i / 32) m_edge[i] = wr_data[i % 32];
        if (a == 'h40 + i / 4) m_prio[i] = int'(wr_data[8 * (i % 4) +: 8]);
        if (a == 'h80 + i / 4) m_tgt[i] = int'(wr_data[8 * (i % 4) +: 8]);
      end
    end
  endtask

  function automatic logic [31:0] model_read(int a);
    logic [31:0] r = '0;
    if (a == 0) r[0] = m_ctrl[0];
    if (a == 1) r = N / 32 - 1;
    for (int i = 0; i < N; i++) begin
      if (a == 'h08 + i / 32 || a == 'h10 + i / 32) r[i % 32] = m_en[i][0];
      if (a == 'h18 + i / 32) r[i % 32] = m_pend[i][0];
      if (a == 'h20 + i / 32) r[i % 32] = m_act[i][0];
      if (a == 'h28 + i / 32) r[i % 32] = (i < 16) ? 1'b1 : m_edge[i][0];
      if (a == 'h40 + i / 4) r[8 * (i % 4) +: 8] = 8'(m_prio[i]);
      if (a == 'h80 + i / 4) r[8 * (i % 4) +: 8] = 8'(m_tgt[i]);
    end
    return r;
  endfunction

  task automatic compare_fwd();
    int v, id, p;
    find_best(v, id, p);
    checks++;
    if (fwd_valid !== v[0] || (v != 0 && (fwd_id !== 6'(id) || fwd_prio !== 8'(p)))) begin
      failures++;
      $display("FAIL %s offer: valid=%0b id=%0d prio=%0d expected valid=%0d id=%0d prio=%0d",
               cur_req, fwd_valid, fwd_id, fwd_prio, v, id, p);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_fwd();
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic ack();
    cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
  endtask

  task automatic eoi(int id);
    eoi_valid = 1'b1; eoi_id = 6'(id); tick(); eoi_valid = 1'b0;
  endtask

  task automatic rd_check(int a);
    logic [31:0] e;
    rd_addr = 8'(a);
    #1;
    e = model_read(a);
    checks++;
    if (rd_data !== e) begin
      failures++;
      $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", cur_req, a, rd_data, e);
    end
  endtask

  initial begin
    m_ctrl = 0;
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0; m_prio[i] = 0;
      m_tgt[i] = 0; m_edge[i] = 0; m_prev[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    // R1: reset state
    cur_req = "R1";
    rd_check('h00); rd_check('h08); rd_check('h18); rd_check('h21);
    rd_check('h40); rd_check('h81); rd_check('h29);
    // R11: line count
    cur_req = "R11";
    rd_check('h01);
    // R12: target and priority packing
    cur_req = "R12";
    for (int k = 0; k < 16; k++) wr('h80 + k, (k == 15) ? 32'h01010100 : 32'h01010101);
    for (int k = 0; k < 16; k++) wr('h40 + k, 32'h80808080);
    rd_check('h8F); rd_check('h40);
    // R6: distributor off blocks offer
    cur_req = "R6";
    swp[3] = 1'b1; tick(); swp = '0;
    wr('h08, 32'h0000_0008);
    tick(); tick();
    wr('h00, 32'h1);
    tick();
    // R9: acknowledge makes active, EOI retires
    cur_req = "R9";
    ack();
    rd_check('h20); rd_check('h18);
    tick();
    eoi(3);
    rd_check('h20);
    // R13: stray acknowledge
    cur_req = "R13";
    ack();
    rd_check('h20); rd_check('h21);
    // R5: priority choice and tie to lowest ID
    cur_req = "R5";
    periph[40] = 1'b1; periph[35] = 1'b1;
    wr('h09, (32'h1 << 8) | (32'h1 << 3));
    tick();
    wr('h4A, 32'h80808010);
    tick();
    rd_check('h4A);
    // R8: level stays pending when active
    cur_req = "R8";
    ack();
    rd_check('h19); rd_check('h21);
    tick();
    eoi(40);
    tick();
    periph[40] = 1'b0;
    tick(); tick();
    rd_check('h19);
    // R4: disabled line not offered
    cur_req = "R4";
    wr('h11, 32'h0000_0008);
    tick();
    rd_check('h19); rd_check('h09);
    // R2 / R3: zero bits change nothing
    cur_req = "R2";
    wr('h09, 32'h0);
    rd_check('h09);
    cur_req = "R3";
    wr('h11, 32'h0);
    rd_check('h11);
    wr('h10, 32'h1);
    rd_check('h10);
    // R7: edge line
    cur_req = "R7";
    rd_check('h28);
    wr('h29, 32'h1 << 18);
    wr('h09, 32'h1 << 18);
    periph[50] = 1'b1; tick(); tick();
    ack();
    rd_check('h19);
    tick();
    eoi(50);
    tick();
    periph[50] = 1'b0; tick();
    periph[50] = 1'b1; tick();
    periph[50] = 1'b0; tick();
    periph[50] = 1'b1; cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
    rd_check('h19); rd_check('h21);
    eoi(50);
    tick();
    // R10: clear-pending write
    cur_req = "R10";
    wr('h19, 32'h0);
    rd_check('h19);
    wr('h19, 32'h1 << 18);
    rd_check('h19);
    tick();
    // R5: non-targeted line never offered
    cur_req = "R5";
    periph[60] = 1'b1;
    wr('h09, 32'h1 << 28);
    tick(); tick();
    // R6: turning off the distributor
    cur_req = "R6";
    swp[7] = 1'b1; tick(); swp = '0;
    wr('h08, 32'h80);
    tick();
    wr('h00, 32'h0);
    tick();
    rd_check('h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule